// File: doc/BRIEF.md
# Command Ring Read Controller

This block is the consumer side of a circular command buffer kept in memory. Software sets up a ring with a base address and a top address, and a read pointer that starts somewhere inside it. The producer's write pointer arrives on an input. When reading is enabled and the ring holds data, the controller sends one 32-byte chunk read at a time to a memory port. It moves the read pointer forward when the memory acknowledges the read. When the pointer leaves the top chunk it goes back to the base.

In linked mode the controller watches three addresses. A breakpoint address stops fetching when the read pointer steps onto it, and fetching stays stopped until software clears it. A low mark fires when the read pointer steps onto it. A high mark fires when the write pointer changes onto it. The producer uses these two marks to throttle itself. Each event gives a one-cycle pulse and sets a sticky status flag. The flags feed an interrupt line through enables in the control register, and a clear register resets the two mark flags.

The block also reports the ring fill (write pointer minus read pointer, modulo the ring size) and a small status word.

Top module: `cmd_fifo_reader`

## Requirements
- R1: A configuration write with `cfg_sel` 2 (base), 3 (top), 4 (read pointer), 5 (breakpoint), 6 (high mark) or 7 (low mark) stores `cfg_wdata` with bits 4:0 forced to zero. Selector 0 writes control and selector 1 writes the clear register.
- R2: A chunk request (`mem_req_o` high, `mem_addr_o` equal to the read pointer) starts only while control bit 0 is set and the fill is nonzero. At most one request is outstanding, it is held with a stable address until `mem_ack_i`, and the read pointer advances by 32 only on that acknowledge.
- R3: When the chunk at the top address is acknowledged, the read pointer reloads to the base address. The wrap itself raises no event and no interrupt.
- R4: `fill_o` equals the write pointer minus the read pointer. When the write pointer is below the read pointer, it equals the write pointer plus (top − base + 32) minus the read pointer.
- R5: With control bits 4 (link) and 5 (breakpoint enable) set, a read-pointer step onto the breakpoint address does three things: it pulses `evt_bp_o` once, it sets status bit 4 and `irq_o`, and it starts no further request.
- R6: A control write with bit 1 set clears status bit 4, and fetching resumes.
- R7: While control bit 4 is clear, no breakpoint, low-mark or high-mark event fires and no status flag is set.
- R8: In linked mode, a read-pointer step onto the low mark pulses `evt_lo_o` once and sets sticky status bit 1. `irq_o` follows bit 1 only while control bit 3 is set.
- R9: In linked mode, a change of the write pointer onto the high mark pulses `evt_hi_o` once, even while the pointer then holds there, and sets sticky status bit 0. `irq_o` follows bit 0 only while control bit 2 is set.
- R10: Writing the clear register with bit 0 set clears status bit 0. Writing it with bit 1 set clears status bit 1.
- R11: Status bit 2 (read idle) is 1 when the fill is zero or when fetching is stopped at a breakpoint. Status bit 3 mirrors `cmd_idle_i`.
- R12: After reset, there is no request, the read pointer and fill are zero, status bits 0, 1 and 4 are clear, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register selector |
| cfg_wdata | input | 32 | Configuration write data |
| wr_ptr_i | input | ADDR_W | Producer write pointer (byte address) |
| cmd_idle_i | input | 1 | Downstream command engine is free |
| mem_req_o | output | 1 | Chunk read request |
| mem_addr_o | output | ADDR_W | Chunk byte address |
| mem_ack_i | input | 1 | Chunk read accepted |
| rd_ptr_o | output | ADDR_W | Current read pointer |
| fill_o | output | ADDR_W | Bytes pending in the ring |
| status_o | output | 5 | {bp hit, cmd idle, read idle, low flag, high flag} |
| irq_o | output | 1 | Interrupt level |
| evt_bp_o | output | 1 | Breakpoint event pulse |
| evt_lo_o | output | 1 | Low-mark event pulse |
| evt_hi_o | output | 1 | High-mark event pulse |

## Verification
The bench first runs the read pointer across the top of the ring. A design that forgets the reload would request addresses past the top, and the scoreboard rejects them. It measures the fill while the write pointer has wrapped and the read pointer has not; a plain subtraction would return a huge value. It then stops the reader at a breakpoint that lands immediately after one acknowledge. A design that detects the hit one cycle late would slip out an extra request, and the scoreboard reports it as unexpected. Last, it holds the write pointer on the high mark for many cycles and repeats the mark sequences with link mode off. This catches level-sensitive events that fire again and again, and gating that ignores the link bit.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_CLR    = 3'd1,
    SEL_BASE   = 3'd2,
    SEL_TOP    = 3'd3,
    SEL_RDPTR  = 3'd4,
    SEL_BRK    = 3'd5,
    SEL_HIMARK = 3'd6,
    SEL_LOMARK = 3'd7
  } cfg_sel_e;

  localparam int CTL_RDEN  = 0;
  localparam int CTL_BPCLR = 1;
  localparam int CTL_HIEN  = 2;
  localparam int CTL_LOEN  = 3;
  localparam int CTL_LINK  = 4;
  localparam int CTL_BPEN  = 5;

  localparam int ST_HI     = 0;
  localparam int ST_LO     = 1;
  localparam int ST_RDIDLE = 2;
  localparam int ST_CMDIDL = 3;
  localparam int ST_BP     = 4;
  localparam int ST_W      = 5;
endpackage

// File: rtl/cfr_regs.sv
module cfr_regs
  import cfr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic              ctl_rden,
  output logic              ctl_hien,
  output logic              ctl_loen,
  output logic              ctl_link,
  output logic              ctl_bpen,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] top_q,
  output logic [ADDR_W-1:0] brk_q,
  output logic [ADDR_W-1:0] hi_q,
  output logic [ADDR_W-1:0] lo_q,
  output logic              rd_load,
  output logic [ADDR_W-1:0] rd_load_val,
  output logic              bp_clr,
  output logic              clr_hi,
  output logic              clr_lo
);
  cfg_sel_e              sel;
  logic [ADDR_W-1:0]     aligned;

  assign sel     = cfg_sel_e'(cfg_sel);
  assign aligned = {cfg_wdata[ADDR_W-1:OFF], {OFF{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_rden <= 1'b0;
      ctl_hien <= 1'b0;
      ctl_loen <= 1'b0;
      ctl_link <= 1'b0;
      ctl_bpen <= 1'b0;
      base_q   <= '0;
      top_q    <= '0;
      brk_q    <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else if (cfg_we) begin
      case (sel)
        SEL_CTRL: begin
          ctl_rden <= cfg_wdata[CTL_RDEN];
          ctl_hien <= cfg_wdata[CTL_HIEN];
          ctl_loen <= cfg_wdata[CTL_LOEN];
          ctl_link <= cfg_wdata[CTL_LINK];
          ctl_bpen <= cfg_wdata[CTL_BPEN];
        end
        SEL_BASE:   base_q <= aligned;
        SEL_TOP:    top_q  <= aligned;
        SEL_BRK:    brk_q  <= aligned;
        SEL_HIMARK: hi_q   <= aligned;
        SEL_LOMARK: lo_q   <= aligned;
        default: ;
      endcase
    end
  end

  assign rd_load     = cfg_we && (sel == SEL_RDPTR);
  assign rd_load_val = aligned;
  assign bp_clr      = cfg_we && (sel == SEL_CTRL) && cfg_wdata[CTL_BPCLR];
  assign clr_hi      = cfg_we && (sel == SEL_CLR) && cfg_wdata[0];
  assign clr_lo      = cfg_we && (sel == SEL_CLR) && cfg_wdata[1];
endmodule

// File: rtl/cfr_fetch.sv
module cfr_fetch #(
  parameter int ADDR_W = 32,
  parameter int OFF    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              halt,
  input  logic              has_data,
  input  logic              rd_load,
  input  logic [ADDR_W-1:0] rd_load_val,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] top,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic              step
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(1) << OFF;

  logic [ADDR_W-1:0] next_ptr;

  // Ring wrap: the top address names the last chunk of the ring.
  always_comb next_ptr = (rd_ptr == top) ? base : rd_ptr + STRIDE;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      rd_ptr   <= '0;
      step     <= 1'b0;
    end else begin
      step <= 1'b0;
      if (rd_load) begin
        rd_ptr  <= rd_load_val;
        mem_req <= 1'b0;
      end else if (mem_req) begin
        if (mem_ack) begin
          rd_ptr  <= next_ptr;
          mem_req <= 1'b0;
          step    <= 1'b1;
        end
      end else if (rd_en && !halt && has_data) begin
        mem_req  <= 1'b1;
        mem_addr <= rd_ptr;
      end
    end
  end
endmodule

// File: rtl/cfr_events.sv
module cfr_events
  import cfr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [ADDR_W-1:0] rd_ptr,
  input  logic [ADDR_W-1:0] wr_ptr,
  input  logic [ADDR_W-1:0] fill,
  input  logic [ADDR_W-1:0] brk,
  input  logic [ADDR_W-1:0] hi_mark,
  input  logic [ADDR_W-1:0] lo_mark,
  input  logic              link,
  input  logic              bpen,
  input  logic              hien,
  input  logic              loen,
  input  logic              bp_clr,
  input  logic              clr_hi,
  input  logic              clr_lo,
  input  logic              cmd_idle,
  output logic              halt,
  output logic [ST_W-1:0]   status,
  output logic [ADDR_W-1:0] fill_q,
  output logic              irq,
  output logic              evt_bp,
  output logic              evt_lo,
  output logic              evt_hi
);
  logic [ADDR_W-1:0] wr_prev;
  logic st_hi, st_lo, st_bp, st_rdidle, st_cmdidle;
  logic bp_fire, lo_fire, hi_fire;

  // Events fire only on the step that lands on the address.
  assign bp_fire = link && bpen && step && (rd_ptr == brk);
  assign lo_fire = link && step && (rd_ptr == lo_mark);
  assign hi_fire = link && (wr_ptr != wr_prev) && (wr_ptr == hi_mark);
  assign halt    = st_bp || bp_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev    <= '0;
      st_hi      <= 1'b0;
      st_lo      <= 1'b0;
      st_bp      <= 1'b0;
      st_rdidle  <= 1'b0;
      st_cmdidle <= 1'b0;
      fill_q     <= '0;
      evt_bp     <= 1'b0;
      evt_lo     <= 1'b0;
      evt_hi     <= 1'b0;
    end else begin
      wr_prev    <= wr_ptr;
      evt_bp     <= bp_fire;
      evt_lo     <= lo_fire;
      evt_hi     <= hi_fire;
      fill_q     <= fill;
      st_rdidle  <= (fill == '0) || halt;
      st_cmdidle <= cmd_idle;
      if (bp_fire)     st_bp <= 1'b1;
      else if (bp_clr) st_bp <= 1'b0;
      if (hi_fire)     st_hi <= 1'b1;
      else if (clr_hi) st_hi <= 1'b0;
      if (lo_fire)     st_lo <= 1'b1;
      else if (clr_lo) st_lo <= 1'b0;
    end
  end

  assign status = {st_bp, st_cmdidle, st_rdidle, st_lo, st_hi};
  assign irq    = (st_hi && hien) || (st_lo && loen) || st_bp;
endmodule

// File: rtl/cmd_fifo_reader.sv
module cmd_fifo_reader
  import cfr_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CHUNK_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic [ADDR_W-1:0] wr_ptr_i,
  input  logic              cmd_idle_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  output logic [ADDR_W-1:0] rd_ptr_o,
  output logic [ADDR_W-1:0] fill_o,
  output logic [ST_W-1:0]   status_o,
  output logic              irq_o,
  output logic              evt_bp_o,
  output logic              evt_lo_o,
  output logic              evt_hi_o
);
  localparam int OFF = $clog2(CHUNK_BYTES);
  localparam logic [ADDR_W-1:0] CHUNK = ADDR_W'(CHUNK_BYTES);

  logic ctl_rden, ctl_hien, ctl_loen, ctl_link, ctl_bpen;
  logic [ADDR_W-1:0] base_q, top_q, brk_q, hi_q, lo_q, rd_load_val;
  logic rd_load, bp_clr, clr_hi, clr_lo, halt, step;
  logic [ADDR_W-1:0] wr_al, ring, fill;
  logic unused_lowbits;

  assign wr_al          = {wr_ptr_i[ADDR_W-1:OFF], {OFF{1'b0}}};
  assign unused_lowbits = ^wr_ptr_i[OFF-1:0];

  // Fill modulo ring size.
  always_comb begin
    ring = top_q - base_q + CHUNK;
    if (wr_al >= rd_ptr_o) fill = wr_al - rd_ptr_o;
    else                   fill = wr_al + ring - rd_ptr_o;
  end

  cfr_regs #(.ADDR_W(ADDR_W), .OFF(OFF)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ctl_rden(ctl_rden), .ctl_hien(ctl_hien), .ctl_loen(ctl_loen),
    .ctl_link(ctl_link), .ctl_bpen(ctl_bpen),
    .base_q(base_q), .top_q(top_q), .brk_q(brk_q), .hi_q(hi_q), .lo_q(lo_q),
    .rd_load(rd_load), .rd_load_val(rd_load_val),
    .bp_clr(bp_clr), .clr_hi(clr_hi), .clr_lo(clr_lo)
  );

  cfr_fetch #(.ADDR_W(ADDR_W), .OFF(OFF)) u_fetch (
    .clk(clk), .rst(rst), .rd_en(ctl_rden), .halt(halt), .has_data(fill != '0),
    .rd_load(rd_load), .rd_load_val(rd_load_val), .base(base_q), .top(top_q),
    .mem_ack(mem_ack_i), .mem_req(mem_req_o), .mem_addr(mem_addr_o),
    .rd_ptr(rd_ptr_o), .step(step)
  );

  cfr_events #(.ADDR_W(ADDR_W)) u_events (
    .clk(clk), .rst(rst), .step(step), .rd_ptr(rd_ptr_o), .wr_ptr(wr_al), .fill(fill),
    .brk(brk_q), .hi_mark(hi_q), .lo_mark(lo_q), .link(ctl_link), .bpen(ctl_bpen),
    .hien(ctl_hien), .loen(ctl_loen), .bp_clr(bp_clr), .clr_hi(clr_hi), .clr_lo(clr_lo),
    .cmd_idle(cmd_idle_i), .halt(halt), .status(status_o), .fill_q(fill_o), .irq(irq_o),
    .evt_bp(evt_bp_o), .evt_lo(evt_lo_o), .evt_hi(evt_hi_o)
  );
endmodule

// File: rtl/cfr_checker.sv
module cfr_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] rd_ptr,
  input logic [ADDR_W-1:0] base,
  input logic [ADDR_W-1:0] top,
  input logic              rd_en,
  input logic              link,
  input logic              rd_load,
  input logic [4:0]        status,
  input logic              evt_bp,
  input logic              evt_lo,
  input logic              evt_hi
);
  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack && !rd_load |=> mem_req && $stable(mem_addr));

  p_no_start_r2: assert property (@(posedge clk) disable iff (rst)
    !mem_req && !rd_en |=> !mem_req);

  p_addr_aligned_r1: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[4:0] == 5'd0);

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack && !rd_load && mem_addr == top |=> rd_ptr == $past(base));

  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack && !rd_load && mem_addr != top |=> rd_ptr == $past(mem_addr) + 32);

  p_bp_halt_r5: assert property (@(posedge clk) disable iff (rst)
    status[4] && !mem_req |=> !mem_req);

  p_nolink_r7: assert property (@(posedge clk) disable iff (rst)
    !link |=> !evt_bp && !evt_lo && !evt_hi);

  p_hi_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    evt_hi |=> !evt_hi);
endmodule

bind cmd_fifo_reader cfr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req_o), .mem_ack(mem_ack_i), .mem_addr(mem_addr_o),
  .rd_ptr(rd_ptr_o), .base(base_q), .top(top_q), .rd_en(ctl_rden), .link(ctl_link),
  .rd_load(rd_load), .status(status_o), .evt_bp(evt_bp_o), .evt_lo(evt_lo_o),
  .evt_hi(evt_hi_o)
);

// File: tb/tb_cmd_fifo_reader.sv
`timescale 1ns/1ps
module tb_cmd_fifo_reader;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [AW-1:0] wr_ptr_i = '0;
  logic cmd_idle_i = 1'b1;
  logic mem_ack_i = 1'b0;
  logic mem_req_o, irq_o, evt_bp_o, evt_lo_o, evt_hi_o;
  logic [AW-1:0] mem_addr_o, rd_ptr_o, fill_o;
  logic [4:0] status_o;

  int n_cmp = 0, n_bad = 0;
  int n_bp = 0, n_lo = 0, n_hi = 0, n_req = 0;
  bit done = 0;
  logic [AW-1:0] exp_q[$];

  always #5 clk = ~clk;

  cmd_fifo_reader #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .wr_ptr_i(wr_ptr_i), .cmd_idle_i(cmd_idle_i), .mem_req_o(mem_req_o),
    .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i), .rd_ptr_o(rd_ptr_o), .fill_o(fill_o),
    .status_o(status_o), .irq_o(irq_o), .evt_bp_o(evt_bp_o), .evt_lo_o(evt_lo_o),
    .evt_hi_o(evt_hi_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Driver side of the scoreboard: expected chunk addresses.
  task automatic expect_chunk(input logic [AW-1:0] a);
    exp_q.push_back(a);
  endtask

  task automatic cfg(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor / memory responder: one-cycle acknowledge, compares each request.
  always @(negedge clk) begin
    if (!rst && mem_req_o && !mem_ack_i) begin
      n_req++;
      if (exp_q.size() == 0) check("R2 unexpected request", mem_addr_o, 32'hFFFF_FFFF);
      else check("R2/R3 chunk address", mem_addr_o, exp_q.pop_front());
      mem_ack_i = 1'b1;
    end else begin
      mem_ack_i = 1'b0;
    end
    if (evt_bp_o) n_bp++;
    if (evt_lo_o) n_lo++;
    if (evt_hi_o) n_hi++;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(3);
    // R12 reset state
    check("R12 no request", {31'd0, mem_req_o}, 32'd0);
    check("R12 read pointer", rd_ptr_o, 32'd0);
    check("R12 fill", fill_o, 32'd0);
    check("R12 status", {27'd0, status_o}, 32'h0C);
    check("R12 irq", {31'd0, irq_o}, 32'd0);

    // R1 alignment, R4 wrapped fill
    cfg(3'd2, 32'h0000_101F);
    cfg(3'd3, 32'h0000_10E0);
    cfg(3'd4, 32'h0000_10D3);
    idle(2);
    check("R1 read pointer aligned", rd_ptr_o, 32'h10C0);
    @(negedge clk) wr_ptr_i = 32'h1047;
    idle(3);
    check("R4 fill after producer wrap", fill_o, 32'h80);

    // R2 read disabled: no requests
    idle(10);
    check("R2 no request while disabled", n_req, 0);

    // R2 + R3 fetch across the top
    expect_chunk(32'h10C0); expect_chunk(32'h10E0);
    expect_chunk(32'h1000); expect_chunk(32'h1020);
    cfg(3'd0, 32'h01);
    idle(30);
    check("R3 pointer after wrap", rd_ptr_o, 32'h1040);
    check("R2 request count", n_req, 4);
    check("R3 no irq on wrap", {31'd0, irq_o}, 32'd0);
    check("R11 read idle when empty", {31'd0, status_o[2]}, 32'd1);

    // R4 plain fill, R5 breakpoint halt
    cfg(3'd0, 32'h30);
    cfg(3'd5, 32'h1060);
    @(negedge clk) wr_ptr_i = 32'h10A0;
    idle(3);
    check("R4 fill", fill_o, 32'h60);
    expect_chunk(32'h1040);
    cfg(3'd0, 32'h31);
    idle(20);
    check("R5 halted pointer", rd_ptr_o, 32'h1060);
    check("R5 request count", n_req, 5);
    check("R5 bp status", {31'd0, status_o[4]}, 32'd1);
    check("R5 irq", {31'd0, irq_o}, 32'd1);
    check("R5 single pulse", n_bp, 1);
    check("R11 read idle at breakpoint", {31'd0, status_o[2]}, 32'd1);

    // R6 breakpoint clear resumes
    expect_chunk(32'h1060); expect_chunk(32'h1080);
    cfg(3'd0, 32'h33);
    idle(20);
    check("R6 pointer after resume", rd_ptr_o, 32'h10A0);
    check("R6 bp status cleared", {31'd0, status_o[4]}, 32'd0);
    check("R6 irq cleared", {31'd0, irq_o}, 32'd0);

    // R7 breakpoint ignored without link
    cfg(3'd5, 32'h10C0);
    cfg(3'd0, 32'h21);
    expect_chunk(32'h10A0); expect_chunk(32'h10C0);
    @(negedge clk) wr_ptr_i = 32'h10E0;
    idle(20);
    check("R7 pointer passes breakpoint", rd_ptr_o, 32'h10E0);
    check("R7 no bp event", n_bp, 1);
    check("R7 no bp status", {31'd0, status_o[4]}, 32'd0);

    // R8 low mark
    cfg(3'd7, 32'h1000);
    expect_chunk(32'h10E0); expect_chunk(32'h1000); expect_chunk(32'h1020);
    cfg(3'd0, 32'h11);
    @(negedge clk) wr_ptr_i = 32'h1040;
    idle(25);
    check("R8 pointer", rd_ptr_o, 32'h1040);
    check("R8 low event once", n_lo, 1);
    check("R8 low status", {31'd0, status_o[1]}, 32'd1);
    check("R8 irq masked", {31'd0, irq_o}, 32'd0);
    cfg(3'd0, 32'h19);
    idle(2);
    check("R8 irq enabled", {31'd0, irq_o}, 32'd1);
    cfg(3'd1, 32'h2);
    idle(2);
    check("R10 low status cleared", {31'd0, status_o[1]}, 32'd0);
    check("R10 irq after clear", {31'd0, irq_o}, 32'd0);

    // R9 high mark
    cfg(3'd0, 32'h14);
    cfg(3'd6, 32'h1080);
    @(negedge clk) wr_ptr_i = 32'h1060;
    idle(3);
    @(negedge clk) wr_ptr_i = 32'h1080;
    idle(5);
    check("R9 high event", n_hi, 1);
    check("R9 high status", {31'd0, status_o[0]}, 32'd1);
    check("R9 irq", {31'd0, irq_o}, 32'd1);
    idle(10);
    check("R9 no refire while holding", n_hi, 1);
    cfg(3'd1, 32'h1);
    idle(2);
    check("R10 high status cleared", {31'd0, status_o[0]}, 32'd0);
    check("R10 irq cleared", {31'd0, irq_o}, 32'd0);

    // R7 high mark ignored without link
    cfg(3'd0, 32'h04);
    @(negedge clk) wr_ptr_i = 32'h1060;
    idle(3);
    @(negedge clk) wr_ptr_i = 32'h1080;
    idle(5);
    check("R7 no high event", n_hi, 1);
    check("R7 no high status", {31'd0, status_o[0]}, 32'd0);

    // R11 command idle mirror and read idle with data pending
    @(negedge clk) cmd_idle_i = 1'b0;
    idle(3);
    check("R11 cmd idle mirror", {31'd0, status_o[3]}, 32'd0);
    check("R11 read idle clear with data", {31'd0, status_o[2]}, 32'd0);
    check("R2 scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule